// File: doc/BRIEF.md
# Shared-RAM Parameter Distributor with Double-Buffered Channels

This block serves a large set of output channels with per-channel parameter words, such as pedestal or threshold corrections, all held in one shared on-chip RAM. Each channel owns a staging register and a live register. The live registers drive the parallel outputs and change only when a global update strobe arrives. The strobe is a slow periodic pulse derived from an external timing tick. On that strobe every staging register is copied into its live register in the same clock cycle.

Once the copy is done, a small sequencer reads every RAM word in turn, highest channel first. It shifts each word into a chain built from the staging registers, one word per clock. After a full pass, staging register k holds RAM word k, ready for the next strobe. A host writes new words straight into the RAM. A sticky flag records any strobe that arrived before the previous refill had finished.

Top module: `param_distributor`

## Requirements
- R1: After reset every live output word is zero, `busy` is 0 and `overrun` is 0.
- R2: On the clock edge where `update_strobe` is sampled high, every live register takes the value of its staging register, all in that same edge.
- R3: From the edge that samples a strobe, `busy` is high for exactly CHANNELS+1 cycles and then drops. This also holds for a strobe that restarts a refill.
- R4: When a refill completes, the next strobe places RAM word k on output channel k, which is `active_words[k*WIDTH +: WIDTH]`, for every k.
- R5: A RAM word written while `busy` is low leaves the outputs unchanged at the first strobe after the write and appears on them at the second strobe.
- R6: `active_words` changes only on an edge that samples `update_strobe` high. In particular it holds steady while a refill shifts the chain.
- R7: A strobe sampled while `busy` is high still performs the transfer and sets `overrun`. `overrun` then stays high until reset. The refill restarts from the highest channel and leaves correct staging contents.
- R8: Staging registers are zero after reset, so the first strobe after reset drives all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for RAM, sequencer and channel registers |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write enable into the parameter RAM |
| host_addr | input | $clog2(CHANNELS) | Channel index of the word being written; indices at or above CHANNELS are dropped |
| host_wdata | input | WIDTH | Parameter word to store |
| update_strobe | input | 1 | Global one-cycle transfer pulse |
| active_words | output | CHANNELS*WIDTH | Live words, channel k at bits k*WIDTH upward |
| busy | output | 1 | High while a refill is reading the RAM or shifting the chain |
| overrun | output | 1 | Sticky: a strobe arrived during a refill |

## Verification
The bench goes after the ordering of the chain: a design that read the RAM in ascending order, or shifted from the wrong end, would put words on the mirrored channels. Off-by-one handling of the RAM read latency would shift every word by one channel and would leave `busy` one cycle short or long. The bench checks the two-strobe delay for host writes, because a design that bypassed the staging stage would show a new word one strobe early. It also fires a strobe in mid-refill: a design that ignored that strobe would miss the transfer and the flag, and one that did not restart the pass would leave stale words in the chain.

// File: rtl/pd_pkg.sv
// Package: shared types for the parameter distributor.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pd_pkg;

    // Refill sequencer state: waiting for a strobe, or issuing RAM reads.
    typedef enum logic {
        RL_IDLE  = 1'b0,
        RL_ISSUE = 1'b1
    } reload_state_e;

endpackage

// File: rtl/param_store.sv
// Module: param_store
// Single shared parameter RAM. One host write port and one registered read
// port with a read latency of one cycle. A read-during-write to the same word
// returns the old content. The valid flag marks the cycle in which read data
// is on rd_data. Out-of-range write addresses are dropped. The contents are
// not reset.
module param_store #(
    parameter int DEPTH = 100,
    parameter int WIDTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Host write into the storage array, range-checked.
    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read data, captured only when a read is issued.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

    // Read-valid flag trailing the read enable by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
        end
    end

endmodule

// File: rtl/reload_seq.sv
// Module: reload_seq
// Refill sequencer. A strobe starts (or restarts) a pass that issues one RAM
// read per cycle, from address N-1 down to 0. busy covers the issue cycles
// plus the trailing cycle in which the last word is still in flight. A strobe
// seen while busy sets the sticky overrun flag. Assumes the RAM has a read
// latency of one cycle, reported through rd_valid.
module reload_seq
    import pd_pkg::*;
#(
    parameter int N  = 100,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          rd_valid,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          overrun
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(N - 1);

    reload_state_e state;
    logic [AW-1:0] idx;

    // State and address counter: a strobe always restarts at the top address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RL_IDLE;
            idx   <= '0;
        end else if (strobe) begin
            state <= RL_ISSUE;
            idx   <= LAST_ADDR;
        end else if (state == RL_ISSUE) begin
            if (idx == '0) begin
                state <= RL_IDLE;
            end else begin
                idx <= idx - 1'b1;
            end
        end
    end

    // Sticky overrun: set by a strobe that lands inside a running pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (strobe && busy) begin
            overrun <= 1'b1;
        end
    end

    // Read request and busy decode.
    always_comb begin
        rd_en   = (state == RL_ISSUE);
        rd_addr = idx;
        busy    = (state == RL_ISSUE) || rd_valid;
    end

endmodule

// File: rtl/shift_chain.sv
// Module: shift_chain
// Per-channel register pair. The staging registers form one shift chain with
// stage 0 at the input end. The live registers load from the staging registers
// in parallel on a transfer pulse. Both are zero after reset.
module shift_chain #(
    parameter int N = 100,
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic [W-1:0]   shift_in,
    input  logic           transfer,
    output logic [N*W-1:0] stage_flat,
    output logic [N*W-1:0] live_flat
);

    logic [W-1:0] stage [N];
    logic [W-1:0] live  [N];

    for (genvar k = 0; k < N; k++) begin : g_ch
        logic [W-1:0] feed;

        // Select the word entering this stage: RAM data at the head, else the neighbour.
        if (k == 0) begin : g_head
            assign feed = shift_in;
        end else begin : g_body
            assign feed = stage[k-1];
        end

        // Staging register: shifts one place per valid RAM word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage[k] <= '0;
            end else if (shift_en) begin
                stage[k] <= feed;
            end
        end

        // Live register: parallel copy of the staging value on a transfer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live[k] <= '0;
            end else if (transfer) begin
                live[k] <= stage[k];
            end
        end

        assign stage_flat[k*W +: W] = stage[k];
        assign live_flat[k*W +: W]  = live[k];
    end

endmodule

// File: rtl/param_distributor.sv
// Module: param_distributor (top)
// Distributes parameter words from one shared RAM to CHANNELS double-buffered
// outputs. A strobe copies staging to live and starts a refill of CHANNELS+1
// cycles that reloads the staging chain from the RAM. Assumes update_strobe
// is a one-cycle pulse in the clk domain, far rarer than one per refill.
module param_distributor #(
    parameter int CHANNELS = 100,
    parameter int WIDTH    = 32,
    localparam int AW      = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_we,
    input  logic [AW-1:0]         host_addr,
    input  logic [WIDTH-1:0]      host_wdata,
    input  logic                  update_strobe,
    output logic [CHANNELS*WIDTH-1:0] active_words,
    output logic                  busy,
    output logic                  overrun
);

    logic                      rd_en;
    logic [AW-1:0]             rd_addr;
    logic [WIDTH-1:0]          rd_data;
    logic                      rd_valid;
    logic [CHANNELS*WIDTH-1:0] next_flat;

    param_store #(
        .DEPTH (CHANNELS),
        .WIDTH (WIDTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_we),
        .wr_addr  (host_addr),
        .wr_data  (host_wdata),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    reload_seq #(
        .N (CHANNELS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (update_strobe),
        .rd_valid (rd_valid),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .busy     (busy),
        .overrun  (overrun)
    );

    shift_chain #(
        .N (CHANNELS),
        .W (WIDTH)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (rd_valid),
        .shift_in   (rd_data),
        .transfer   (update_strobe),
        .stage_flat (next_flat),
        .live_flat  (active_words)
    );

endmodule

// File: rtl/pd_checker.sv
// Module: pd_checker
// Property checker for param_distributor, attached by the bind below.
// The refill window length is measured with a local counter, not with a delay.
module pd_checker #(
    parameter int N = 100,
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           update_strobe,
    input logic           busy,
    input logic           overrun,
    input logic [N*W-1:0] active_words,
    input logic [N*W-1:0] next_flat
);

    localparam int CW = $clog2(N + 3);

    logic [CW-1:0] busy_cnt;

    // Busy-cycle counter, restarted by every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (update_strobe) begin
            busy_cnt <= '0;
        end else if (busy && (busy_cnt != {CW{1'b1}})) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    AST_TRANSFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        update_strobe |=> (active_words == $past(next_flat))); // R2

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        update_strobe |=> busy); // R3

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(update_strobe)) |-> (int'(busy_cnt) == N + 1)); // R3

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !update_strobe |=> $stable(active_words)); // R6

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (update_strobe && busy) |=> overrun); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R7

endmodule

bind param_distributor pd_checker #(
    .N (CHANNELS),
    .W (WIDTH)
) u_pd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .update_strobe (update_strobe),
    .busy          (busy),
    .overrun       (overrun),
    .active_words  (active_words),
    .next_flat     (next_flat)
);

// File: tb/test_param_distributor.sv
// Bench for param_distributor: a table of write patterns walked by one loop,
// then directed tests for reset, single-word updates and mid-refill strobes.
module test_param_distributor;

    localparam int N  = 8;
    localparam int W  = 16;
    localparam int AW = $clog2(N);
    localparam int ROUNDS = 4;
    localparam logic [W-1:0] SEEDS [ROUNDS] = '{16'h1111, 16'hA5A5, 16'h0000, 16'hFFFF};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_we = 1'b0;
    logic [AW-1:0]  host_addr = '0;
    logic [W-1:0]   host_wdata = '0;
    logic           update_strobe = 1'b0;
    logic [N*W-1:0] active_words;
    logic           busy;
    logic           overrun;

    int n_checks = 0;
    int n_fails  = 0;
    logic [W-1:0] model [N];

    always #5 clk = ~clk;

    param_distributor #(.CHANNELS(N), .WIDTH(W)) i_param_distributor (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_we       (host_we),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .update_strobe (update_strobe),
        .active_words  (active_words),
        .busy          (busy),
        .overrun       (overrun)
    );

    function automatic logic [W-1:0] pat(input logic [W-1:0] seed, input int k);
        return seed ^ W'(k * 16'h1357 + k + 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [W-1:0] d);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = AW'(a);
        host_wdata = d;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        update_strobe = 1'b1;
        @(negedge clk);
        update_strobe = 1'b0;
    endtask

    // Compare every output channel against a list of expected words.
    task automatic chk_outputs(input string req, input logic [W-1:0] exp [N]);
        for (int k = 0; k < N; k++) begin
            chk(req, 32'(active_words[k*W +: W]), 32'(exp[k]));
        end
    endtask

    // Wait out a refill; check its length (R3) and output stability (R6).
    task automatic wait_refill();
        int cycles = 0;
        logic [N*W-1:0] snap = active_words;
        bit moved = 1'b0;
        while (busy && cycles < 4 * N) begin
            if (active_words !== snap) moved = 1'b1;
            cycles++;
            @(negedge clk);
        end
        chk("R3 busy length", 32'(cycles), 32'(N + 1));
        chk("R6 outputs held during refill", 32'(moved), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [W-1:0] zeros [N];
        logic [W-1:0] prev  [N];
        for (int k = 0; k < N; k++) zeros[k] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_outputs("R1 reset outputs", zeros);
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset overrun", 32'(overrun), 32'd0);

        // Clear the RAM, then the first strobe shows the zeroed staging (R8).
        for (int k = 0; k < N; k++) host_write(k, '0);
        strobe();
        chk_outputs("R8 first strobe zero", zeros);
        chk("R3 busy after strobe", 32'(busy), 32'd1);
        wait_refill();
        prev = zeros;

        // Pattern table: old words at the first strobe (R5), new at the second (R4).
        for (int r = 0; r < ROUNDS; r++) begin
            for (int k = 0; k < N; k++) begin
                model[k] = pat(SEEDS[r], k);
                host_write(k, model[k]);
            end
            strobe();
            chk_outputs("R5 old words at first strobe", prev);
            wait_refill();
            strobe();
            chk_outputs("R4 channel k carries word k", model);
            wait_refill();
            prev = model;
        end

        // Single-word write: one channel changes, two strobes later (R5).
        host_write(N - 2, 16'hBEEF);
        strobe();
        chk("R5 single word not yet", 32'(active_words[(N-2)*W +: W]), 32'(prev[N-2]));
        wait_refill();
        strobe();
        model[N-2] = 16'hBEEF;
        chk_outputs("R5 single word applied", model);
        wait_refill();
        chk("R7 no overrun so far", 32'(overrun), 32'd0);

        // Mid-refill strobe: transfer still happens, overrun sticks, refill restarts (R7).
        for (int k = 0; k < N; k++) host_write(k, ~pat(16'h3C3C, k));
        strobe();
        repeat (3) @(negedge clk);
        strobe();
        chk("R7 overrun set", 32'(overrun), 32'd1);
        wait_refill();
        strobe();
        for (int k = 0; k < N; k++) model[k] = ~pat(16'h3C3C, k);
        chk_outputs("R7 contents after restart", model);
        wait_refill();
        chk("R7 overrun sticky", 32'(overrun), 32'd1);

        // Reset clears the flag and the registers again (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 overrun cleared", 32'(overrun), 32'd0);
        chk_outputs("R1 outputs cleared", zeros);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule